// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command and address pins of a four-bank SDRAM from reset until the memory is ready for normal traffic. While the device settles, it keeps the clock enable and the data masks high and presents a no-operation command. The settle time is a cycle count derived from the clock frequency. After that it closes every bank with one precharge-all command. It then issues a configurable number of auto-refresh commands. It programs the standard mode register and the low-power extended mode register. Finally it raises a done flag.

The refresh phase and the register-programming phase can run in either order, chosen by a parameter. A programmable number of no-operation cycles separates each command from the next, which covers the row-precharge, refresh-cycle and register-set recovery times. Once the flag is raised, the block stays idle until the next reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and during the settle period, `mem_cke` is 1, every bit of `mem_dqm` is 1, and the command is NOP (`mem_cs_n`=0, `mem_ras_n`=1, `mem_cas_n`=1, `mem_we_n`=1) with `mem_ba`=0 and `mem_addr`=0.
- R2: The settle period lasts exactly SETTLE_CYC cycles. The first non-NOP command appears in the cycle that follows the SETTLE_CYC-th rising edge after reset is released.
- R3: The first command is precharge-all: `mem_cs_n`=0, `mem_ras_n`=0, `mem_cas_n`=1, `mem_we_n`=0, `mem_addr` bit 10 = 1, all other address bits 0, `mem_ba`=0.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued (`mem_cs_n`=0, `mem_ras_n`=0, `mem_cas_n`=0, `mem_we_n`=1, `mem_addr`=0, `mem_ba`=0). TRP_GAP NOP cycles follow the precharge and TRFC_GAP NOP cycles follow each refresh.
- R5: The mode-register write drives all four command pins low with `mem_ba`=00. `mem_addr` equals `base_mode` with bits 7, 8, 10 and 11 forced to 0.
- R6: The extended-register write uses the same command encoding with `mem_ba`=10 (bit 1 high, bit 0 low) and `mem_addr`=`ext_mode`. It follows the mode-register write after MRD_GAP NOP cycles.
- R7: With MODE_FIRST=0, the order is precharge, refreshes, mode, extended mode. With MODE_FIRST=1, it is precharge, mode, extended mode, refreshes, and MRD_GAP NOPs follow the extended write.
- R8: `init_done` rises one cycle after the extended write when that write is last, or after the final TRFC_GAP NOPs when a refresh is last. It then stays 1, and the command stays NOP, until reset.
- R9: An asynchronous reset at any point returns the block to the start of the settle period with `init_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_mode | input | ROW_W | Value for the standard mode register |
| ext_mode | input | ROW_W | Value for the extended low-power register |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| mem_dqm | output | DQM_W | Data masks |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | ROW_W | Address bus |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
A wrong internal state moves a command to the wrong cycle, changes a command's encoding, or alters the count of refreshes. The bench compares every pin in every cycle against a schedule computed from the parameters, so the error shows up in the first cycle that deviates. Usually that is the cycle of the command after the faulty state, and at the latest it is the cycle in which `init_done` should rise. Random mode values that change every cycle show whether the register-set cycles pass the live inputs through with the correct masking and bank bits. Resets cut into random points of the sequence show whether stale counters survive a restart.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ       = 250,
  parameter int SETTLE_US     = 200,
  parameter int SETTLE_CYC    = CLK_MHZ * SETTLE_US,
  parameter int REFRESH_COUNT = 2,
  parameter int TRP_GAP       = 2,
  parameter int TRFC_GAP      = 7,
  parameter int MRD_GAP       = 2,
  parameter bit MODE_FIRST    = 1'b0,
  parameter int ROW_W         = 12,
  parameter int DQM_W         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] base_mode,
  input  logic [ROW_W-1:0] ext_mode,
  output logic             mem_cs_n,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic             mem_cke,
  output logic [DQM_W-1:0] mem_dqm,
  output logic [1:0]       mem_ba,
  output logic [ROW_W-1:0] mem_addr,
  output logic             init_done
);

  localparam int G1   = (TRP_GAP > TRFC_GAP) ? TRP_GAP : TRFC_GAP;
  localparam int G2   = (G1 > MRD_GAP) ? G1 : MRD_GAP;
  localparam int MAXV = (SETTLE_CYC > G2) ? SETTLE_CYC : G2;
  localparam int CW   = $clog2(MAXV + 1);
  localparam int RW   = $clog2(REFRESH_COUNT + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  function automatic logic [ROW_W-1:0] reserved_clear();
    logic [ROW_W-1:0] m;
    for (int i = 0; i < ROW_W; i++)
      m[i] = !(i == 7 || i == 8 || i == 10 || i == 11);
    return m;
  endfunction
  localparam logic [ROW_W-1:0] MRS_MASK = reserved_clear();

  typedef enum logic [2:0] {S_SETTLE, S_PRE, S_REF, S_MRS, S_EMRS, S_WAIT, S_DONE} st_t;

  st_t           st, after;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;
  logic [3:0]    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_SETTLE;
      after <= S_PRE;
      cnt   <= CW'(SETTLE_CYC - 1);
      refs  <= '0;
    end else begin
      case (st)
        S_SETTLE: if (cnt == '0) st <= S_PRE; else cnt <= cnt - 1'b1;
        S_PRE: begin
          st    <= S_WAIT;
          cnt   <= CW'(TRP_GAP - 1);
          after <= MODE_FIRST ? S_MRS : S_REF;
        end
        S_REF: begin
          refs <= refs + 1'b1;
          st   <= S_WAIT;
          cnt  <= CW'(TRFC_GAP - 1);
          if (refs == RW'(REFRESH_COUNT - 1)) after <= MODE_FIRST ? S_DONE : S_MRS;
          else                                after <= S_REF;
        end
        S_MRS: begin
          st    <= S_WAIT;
          cnt   <= CW'(MRD_GAP - 1);
          after <= S_EMRS;
        end
        S_EMRS: begin
          if (MODE_FIRST) begin
            st    <= S_WAIT;
            cnt   <= CW'(MRD_GAP - 1);
            after <= S_REF;
          end else begin
            st <= S_DONE;
          end
        end
        S_WAIT: if (cnt == '0) st <= after; else cnt <= cnt - 1'b1;
        default: st <= S_DONE;
      endcase
    end
  end

  always_comb begin
    cmd      = CMD_NOP;
    mem_ba   = 2'b00;
    mem_addr = '0;
    case (st)
      S_PRE:  begin cmd = CMD_PRE; mem_addr[10] = 1'b1; end
      S_REF:  cmd = CMD_REF;
      S_MRS:  begin cmd = CMD_MRS; mem_addr = base_mode & MRS_MASK; end
      S_EMRS: begin cmd = CMD_MRS; mem_ba = 2'b10; mem_addr = ext_mode; end
      default: ;
    endcase
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
  assign mem_cke   = 1'b1;
  assign mem_dqm   = '1;
  assign init_done = (st == S_DONE);

  logic [RW:0] ref_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_seen <= '0;
    else if (cmd == CMD_REF) ref_seen <= ref_seen + 1'b1;
  end

  assert_settle_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |-> (cmd == CMD_NOP && mem_cke && (&mem_dqm)));

  assert_first_cmd_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE && cnt == '0) |=> (cmd == CMD_PRE));

  assert_cmd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

  assert_ref_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ref_seen == (RW+1)'(REFRESH_COUNT)));

  assert_mrs_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && mem_ba == 2'b00) |-> (mem_addr[8:7] == 2'b00 && mem_addr[11:10] == 2'b00));

  assert_emrs_after_mrs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS && mem_ba == 2'b10) |-> (after == S_EMRS));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == CMD_NOP));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int A_S = 37, A_NR = 2, A_TRP = 2, A_TRFC = 5, A_MRD = 2;
  localparam int B_S = 20, B_NR = 3, B_TRP = 1, B_TRFC = 3, B_MRD = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bm = '0, em = '0;
  always #2 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_done;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_done;
  logic [1:0]  a_dqm, b_dqm, a_ba, b_ba;
  logic [11:0] a_addr, b_addr;

  sdram_init_seq #(.SETTLE_CYC(A_S), .REFRESH_COUNT(A_NR), .TRP_GAP(A_TRP), .TRFC_GAP(A_TRFC),
                   .MRD_GAP(A_MRD), .MODE_FIRST(1'b0)) i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .base_mode(bm), .ext_mode(em),
    .mem_cs_n(a_cs), .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we),
    .mem_cke(a_cke), .mem_dqm(a_dqm), .mem_ba(a_ba), .mem_addr(a_addr), .init_done(a_done));

  sdram_init_seq #(.SETTLE_CYC(B_S), .REFRESH_COUNT(B_NR), .TRP_GAP(B_TRP), .TRFC_GAP(B_TRFC),
                   .MRD_GAP(B_MRD), .MODE_FIRST(1'b1)) i_sdram_init_seq_alt (
    .clk(clk), .rst_n(rst_n), .base_mode(bm), .ext_mode(em),
    .mem_cs_n(b_cs), .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we),
    .mem_cke(b_cke), .mem_dqm(b_dqm), .mem_ba(b_ba), .mem_addr(b_addr), .init_done(b_done));

  int checks = 0, errors = 0, tcnt = 0;

  always @(posedge clk) begin
    if (!rst_n) tcnt <= 0;
    else        tcnt <= tcnt + 1;
  end

  localparam logic [18:0] E_NOP = {1'b0, 4'b0111, 2'b00, 12'h000};

  function automatic logic [18:0] exp_out(int t, int s, int nr, int trp, int trfc, int mrd,
                                          bit mf, logic [11:0] b, logic [11:0] e);
    logic [18:0] pre_v, ref_v, mrs_v, emrs_v;
    int p;
    pre_v  = {1'b0, 4'b0010, 2'b00, 12'h400};
    ref_v  = {1'b0, 4'b0001, 2'b00, 12'h000};
    mrs_v  = {1'b0, 4'b0000, 2'b00, b & 12'h27F};
    emrs_v = {1'b0, 4'b0000, 2'b10, e};
    if (t < s) return E_NOP;
    p = s;
    if (t == p) return pre_v;
    p += 1 + trp;
    if (mf) begin
      if (t == p) return mrs_v;
      p += 1 + mrd;
      if (t == p) return emrs_v;
      p += 1 + mrd;
      for (int i = 0; i < nr; i++) begin
        if (t == p) return ref_v;
        p += 1 + trfc;
      end
    end else begin
      for (int i = 0; i < nr; i++) begin
        if (t == p) return ref_v;
        p += 1 + trfc;
      end
      if (t == p) return mrs_v;
      p += 1 + mrd;
      if (t == p) return emrs_v;
      p += 1;
    end
    if (t >= p) return {1'b1, 4'b0111, 2'b00, 12'h000};
    return E_NOP;
  endfunction

  function automatic string req_of(logic [18:0] e, int t, int s, bit in_rst, bit mf);
    if (in_rst) return "R9";
    if (t < s) return "R2";
    if (e[18]) return "R8";
    case (e[17:14])
      4'b0010: return "R3";
      4'b0001: return mf ? "R7" : "R4";
      4'b0000: return (e[13:12] == 2'b10) ? "R6" : "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic check_one(string nm, int s, int nr, int trp, int trfc, int mrd, bit mf,
                           logic [18:0] act, logic cke, logic [1:0] dqm);
    logic [18:0] e;
    string rq;
    e  = (!rst_n) ? E_NOP : exp_out(tcnt, s, nr, trp, trfc, mrd, mf, bm, em);
    rq = req_of(e, tcnt, s, !rst_n, mf);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s %s t=%0d: actual done/cmd/ba/addr=%h expected %h", rq, nm, tcnt, act, e);
    end
    checks++;
    if (cke !== 1'b1 || dqm !== 2'b11) begin
      errors++;
      $display("FAIL R1 %s t=%0d: actual cke=%b dqm=%b expected cke=1 dqm=11", nm, tcnt, cke, dqm);
    end
  endtask

  task automatic sample_all();
    @(negedge clk);
    check_one("A", A_S, A_NR, A_TRP, A_TRFC, A_MRD, 1'b0,
              {a_done, a_cs, a_ras, a_cas, a_we, a_ba, a_addr}, a_cke, a_dqm);
    check_one("B", B_S, B_NR, B_TRP, B_TRFC, B_MRD, 1'b1,
              {b_done, b_cs, b_ras, b_cas, b_we, b_ba, b_addr}, b_cke, b_dqm);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still active, expected completion");
    finish_run();
  end

  initial begin
    int len;
    void'($urandom(32'h5D1A));
    for (int run = 0; run < 30; run++) begin
      rst_n = 1'b0;
      if (run == 0)      begin bm = 12'hFFF; em = 12'hFFF; end
      else if (run == 1) begin bm = 12'h000; em = 12'h000; end
      else               begin bm = 12'($urandom); em = 12'($urandom); end
      repeat (1 + $urandom % 3) sample_all();
      @(posedge clk); #1 rst_n = 1'b1;
      len = (run % 3 == 2) ? 3 + int'($urandom % 50) : 90;
      for (int c = 0; c < len; c++) begin
        sample_all();
        @(posedge clk); #1;
        if (run > 1 && ($urandom % 2) == 1) begin
          bm = 12'($urandom);
          em = 12'($urandom);
        end
      end
    end
    finish_run();
  end
endmodule